// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for one memory access at a time, whether the access is allowed. It keeps a table of sixteen programmable protection windows. Each window has a start address, a power-of-two length with an enable bit and eight subwindow masks, and a control word with a three-bit permission code and a no-execute bit. A request presents an address, the kind of access, whether the requester runs unprivileged, and three global controls: protection on, background map allowed, and high exception vectors. One cycle later the block returns read, write and execute rights for that address, a fault flag, a four-bit fault code and a separate flag for a miss with no background map.

Windows may overlap. The one with the largest index that claims the address wins. A window of 256 bytes or more is cut into eight equal slices, and each slice can be masked so that the address is handed to lower-numbered windows. When protection is off, or when a privileged access misses every window while the background map is allowed, a fixed default map applies.

Top module: `mpc_checker`

## Requirements
- R1: After reset every window is disabled and rsp_valid is low. With protection on and no window programmed, an unprivileged request returns bg_fault=1, fault=1, fault_status=0 and all three rights low.
- R2: When several enabled windows claim an address, the one with the highest index supplies the rights.
- R3: A window claims addresses from its base up to base + 2^(K+1) − 1, where K is size word bits 5:1 and bit 0 is the enable. Addresses outside that range, and any address of a disabled window, are not claimed.
- R4: In a window of 256 bytes or more, the slice index is (addr − base) / (length/8). When size word bit 8+slice is set, that window does not claim the address and lower-numbered windows are searched.
- R5: In a window smaller than 256 bytes, size word bits 15:8 have no effect.
- R6: For an unprivileged access the permission code (control word bits 10:8) gives: 0, 1, 5 → none; 2, 6 → read and execute; 3 → read, write and execute; 4, 7 → none.
- R7: For a privileged access the code gives: 0 → none; 1, 2, 3 → read, write and execute; 5, 6 → read and execute; 4, 7 → none.
- R8: Control word bit 12 set clears execute rights of the window that wins.
- R9: With protection on and no window claiming the address, an unprivileged request or a request with the background control low gives bg_fault=1, fault=1, fault_status=0 and no rights.
- R10: The default map (protection off, or a privileged miss with the background control high) grants read and write everywhere, execute below 0x80000000, and execute at 0xF0000000 and above only when high vectors are selected.
- R11: Access kind 0 needs read, 1 write, 2 execute; kind 3 is always refused. A refused access, other than a background miss, sets fault=1 and fault_status=0xD, and leaves bg_fault low.
- R12: The result appears in the cycle after req_valid with rsp_valid high, and holds with rsp_valid low while no request is made. Config select 0 writes the base, 1 the size word, 2 the control word; select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window table write strobe |
| cfg_idx | input | 4 | Window index to write |
| cfg_sel | input | 2 | Word to write: 0 base, 1 size, 2 control, 3 none |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Check request strobe |
| req_addr | input | 32 | Address to check |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 refused |
| req_user | input | 1 | Unprivileged requester |
| mpu_on | input | 1 | Protection enabled |
| bg_on | input | 1 | Background map allowed for privileged misses |
| hivec | input | 1 | High exception vectors selected |
| rsp_valid | output | 1 | Result registered from the previous cycle's request |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |
| fault | output | 1 | Access refused |
| fault_status | output | 4 | 0xD for a rights fault, 0 otherwise |
| bg_fault | output | 1 | No window claimed and no background map allowed |

## Verification
The hardest state to reach is a masked slice of a high-priority window that sits on top of a lower window, where the answer must come from the lower one while the higher one still matches the range. Directed cases stack a 1 KB read-only window on a 4 KB full-access window and mask one slice, then probe both sides of the slice edges. Random runs place sixteen windows with random masks in a 16 MB span, so overlaps and masked slices are common, and aim most addresses inside programmed windows; every answer is compared with a bench model of the search.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_BAD = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CSEL_BASE = 2'd0,
        CSEL_SIZE = 2'd1,
        CSEL_CTRL = 2'd2,
        CSEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] size_w;
        logic [WORD_W-1:0] ctrl_w;
    } region_cfg_t;

    typedef struct packed {
        perm_t      perm;
        logic       fault;
        logic [3:0] status;
        logic       bgf;
    } chk_res_t;

    localparam logic [3:0] FS_PERM = 4'hD;
    localparam int         SUBR_MIN_LOG = 8;

    function automatic perm_t ap_decode(input logic [2:0] ap, input logic user);
        perm_t p;
        p = '0;
        if (user) begin
            case (ap)
                3'd2, 3'd6: p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
                3'd3:       p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
                default:    p = '0;
            endcase
        end else begin
            case (ap)
                3'd1, 3'd2, 3'd3: p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
                3'd5, 3'd6:       p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
                default:          p = '0;
            endcase
        end
        return p;
    endfunction

    function automatic perm_t default_map(input logic [WORD_W-1:0] a, input logic hv);
        perm_t p;
        p.rd = 1'b1;
        p.wr = 1'b1;
        p.ex = !a[WORD_W-1] || ((a[WORD_W-1 -: 4] == 4'hF) && hv);
        return p;
    endfunction

    function automatic logic perm_ok(input perm_t p, input acc_kind_e k);
        case (k)
            ACC_RD:  return p.rd;
            ACC_WR:  return p.wr;
            ACC_EX:  return p.ex;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mpc_region_bank.sv
module mpc_region_bank
    import mpc_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        sel,
    input  logic [WORD_W-1:0] wdata,
    output region_cfg_t       cfg_o [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        region_cfg_t q;
        logic        hit_me;

        assign hit_me = we && (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit_me) begin
                case (cfg_sel_e'(sel))
                    CSEL_BASE: q.base   <= wdata;
                    CSEL_SIZE: q.size_w <= wdata;
                    CSEL_CTRL: q.ctrl_w <= wdata;
                    default:   q        <= q;
                endcase
            end
        end

        assign cfg_o[g] = q;

        a_r1_reset_disabled: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !q.size_w[0]);
    end

endmodule

// File: rtl/mpc_region_match.sv
module mpc_region_match
    import mpc_pkg::*;
(
    input  region_cfg_t       cfg,
    input  logic [WORD_W-1:0] addr,
    output logic              hit
);

    logic [5:0]        rsize;
    logic [WORD_W:0]   span;
    logic [WORD_W-1:0] off;
    logic              in_rng;
    logic [5:0]        sh;
    logic [2:0]        slice;
    logic [7:0]        mask;
    logic              masked;

    always_comb begin
        rsize  = {1'b0, cfg.size_w[5:1]} + 6'd1;
        span   = (WORD_W+1)'(1) << rsize;
        off    = addr - cfg.base;
        in_rng = (addr >= cfg.base) && ({1'b0, off} < span);
        sh     = rsize - 6'd3;
        slice  = 3'(off >> sh);
        mask   = cfg.size_w[15:8];
        masked = (rsize >= 6'(SUBR_MIN_LOG)) && mask[slice];
        hit    = cfg.size_w[0] && in_rng && !masked;
    end

endmodule

// File: rtl/mpc_prio_pick.sv
module mpc_prio_pick #(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREG-1:0]  hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    a_r2_winner_claims: assert property (@(posedge clk) disable iff (rst)
        any |-> hits[idx]);
    a_r2_none_above: assert property (@(posedge clk) disable iff (rst)
        any |-> ((hits >> idx) == NREG'(1)));
    a_r2_any_matches: assert property (@(posedge clk) disable iff (rst)
        any == (hits != '0));

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
    import mpc_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic              mpu_on,
    input  logic              bg_on,
    input  logic              hivec,
    output logic              rsp_valid,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x,
    output logic              fault,
    output logic [3:0]        fault_status,
    output logic              bg_fault
);

    region_cfg_t      cfg [NREG];
    logic [NREG-1:0]  hits;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    region_cfg_t      win_cfg;
    perm_t            dflt;
    chk_res_t         res_d;
    chk_res_t         res_q;
    logic             vld_q;

    mpc_region_bank #(.NREG(NREG)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_match
        mpc_region_match u_match (
            .cfg  (cfg[g]),
            .addr (req_addr),
            .hit  (hits[g])
        );
    end

    mpc_prio_pick #(.NREG(NREG)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .hits (hits),
        .any  (any_hit),
        .idx  (win_idx)
    );

    assign win_cfg = cfg[win_idx];
    assign dflt    = default_map(req_addr, hivec);

    always_comb begin
        res_d = '0;
        if (!mpu_on) begin
            res_d.perm = dflt;
        end else if (any_hit) begin
            res_d.perm = ap_decode(win_cfg.ctrl_w[10:8], req_user);
            if (win_cfg.ctrl_w[12]) begin
                res_d.perm.ex = 1'b0;
            end
        end else if (req_user || !bg_on) begin
            res_d.bgf   = 1'b1;
            res_d.fault = 1'b1;
        end else begin
            res_d.perm = dflt;
        end
        if (!res_d.bgf && !perm_ok(res_d.perm, acc_kind_e'(req_kind))) begin
            res_d.fault  = 1'b1;
            res_d.status = FS_PERM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign rsp_valid    = vld_q;
    assign perm_r       = res_q.perm.rd;
    assign perm_w       = res_q.perm.wr;
    assign perm_x       = res_q.perm.ex;
    assign fault        = res_q.fault;
    assign fault_status = res_q.status;
    assign bg_fault     = res_q.bgf;

    a_r8_no_exec: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mpu_on && any_hit && win_cfg.ctrl_w[12]) |=> !perm_x);
    a_r9_bg_clean: assert property (@(posedge clk) disable iff (rst)
        bg_fault |-> (fault && fault_status == 4'h0 && !perm_r && !perm_w && !perm_x));
    a_r11_perm_code: assert property (@(posedge clk) disable iff (rst)
        (fault && !bg_fault) |-> (fault_status == FS_PERM));
    a_r10_off_rw: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mpu_on) |=> (perm_r && perm_w && !bg_fault));
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !$past(rst)) |=> ($stable(perm_r) && $stable(fault_status) && $stable(fault)));

endmodule

// File: tb/sim_mpc_checker.sv
module sim_mpc_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        mpu_on = 1'b0;
    logic        bg_on = 1'b0;
    logic        hivec = 1'b0;
    logic        rsp_valid, perm_r, perm_w, perm_x, fault, bg_fault;
    logic [3:0]  fault_status;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] m_base [16];
    logic [31:0] m_size [16];
    logic [31:0] m_ctrl [16];

    always #5 clk = ~clk;

    mpc_checker u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_user(req_user), .mpu_on(mpu_on), .bg_on(bg_on),
        .hivec(hivec), .rsp_valid(rsp_valid), .perm_r(perm_r), .perm_w(perm_w),
        .perm_x(perm_x), .fault(fault), .fault_status(fault_status), .bg_fault(bg_fault)
    );

    // result packing: {r, w, x, fault, status[3:0], bg}
    function automatic logic [8:0] model(logic [31:0] a, logic [1:0] k, logic u,
                                         logic mpu, logic bg, logic hv);
        logic r, w, x, f, b, need;
        logic [3:0] st;
        int hit;
        r = 0; w = 0; x = 0; f = 0; b = 0; st = 0; hit = -1;
        if (mpu) begin
            for (int n = 15; n >= 0; n--) begin
                if (hit < 0 && m_size[n][0]) begin
                    longint unsigned lo, len, rs, snd;
                    lo  = 64'(m_base[n]);
                    rs  = 64'(m_size[n][5:1]) + 1;
                    len = 64'd1 << rs;
                    if (64'(a) >= lo && 64'(a) <= lo + len - 1) begin
                        if (rs < 8) hit = n;
                        else begin
                            snd = ((64'(a) - lo) >> (rs - 3)) & 64'd7;
                            if (!m_size[n][8 + int'(snd)]) hit = n;
                        end
                    end
                end
            end
        end
        if (!mpu || (hit < 0 && !u && bg)) begin
            r = 1; w = 1;
            x = (a < 32'h8000_0000) || (a >= 32'hF000_0000 && hv);
        end else if (hit < 0) begin
            b = 1; f = 1;
        end else begin
            logic [2:0] ap;
            ap = m_ctrl[hit][10:8];
            if (u) begin
                if (ap == 3) begin r = 1; w = 1; x = 1; end
                else if (ap == 2 || ap == 6) begin r = 1; x = 1; end
            end else begin
                if (ap >= 1 && ap <= 3) begin r = 1; w = 1; x = 1; end
                else if (ap == 5 || ap == 6) begin r = 1; x = 1; end
            end
            if (m_ctrl[hit][12]) x = 0;
        end
        if (!b) begin
            need = (k == 0) ? r : (k == 1) ? w : (k == 2) ? x : 1'b0;
            if (!need) begin f = 1; st = 4'hD; end
        end
        return {r, w, x, f, st, b};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(int idx, int sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
        if (sel == 0) m_base[idx] = d;
        if (sel == 1) m_size[idx] = d;
        if (sel == 2) m_ctrl[idx] = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic region(int idx, logic [31:0] base, logic [31:0] size_w, logic [31:0] ctrl);
        cfg_write(idx, 0, base);
        cfg_write(idx, 1, size_w);
        cfg_write(idx, 2, ctrl);
    endtask

    function automatic logic [8:0] outs();
        return {perm_r, perm_w, perm_x, fault, fault_status, bg_fault};
    endfunction

    task automatic probe(string tag, logic [31:0] a, logic [1:0] k, logic u,
                         logic mpu, logic bg, logic hv);
        logic [8:0] exp;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_kind = k; req_user = u;
        mpu_on = mpu; bg_on = bg; hivec = hv;
        exp = model(a, k, u, mpu, bg, hv);
        @(negedge clk);
        req_valid = 0;
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check(tag, 32'(outs()), 32'(exp));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_size[i] = 0; m_ctrl[i] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 rsp_valid low after reset", 32'(rsp_valid), 32'd0);
        check("R1 outputs clear after reset", 32'(outs()), 32'd0);
        probe("R1 empty table user bg fault", 32'h0000_1000, 0, 1, 1, 1, 0);
        check("R1 explicit bg pattern", 32'(outs()), 32'b000_1_0000_1);
        probe("R9 priv miss with bg off", 32'h0000_1000, 0, 0, 1, 0, 0);
        check("R9 explicit bg pattern", 32'(outs()), 32'b000_1_0000_1);

        // R3: 4 KB window, full access
        region(0, 32'h0000_1000, {26'd0, 5'd11, 1'b1}, 32'h0000_0300);
        probe("R3 last byte in", 32'h0000_1FFF, 1, 1, 1, 1, 0);
        check("R3 last byte write ok", 32'(outs()), 32'b111_0_0000_0);
        probe("R3 one past end", 32'h0000_2000, 0, 1, 1, 1, 0);
        check("R3 past end bg", 32'(bg_fault), 32'd1);
        probe("R3 below base", 32'h0000_0FFF, 0, 1, 1, 1, 0);

        // R2: 1 KB read-only window on top
        region(5, 32'h0000_1000, {26'd0, 5'd9, 1'b1}, 32'h0000_0600);
        probe("R2 upper window wins", 32'h0000_1100, 1, 1, 1, 1, 0);
        check("R2 write refused 0xD", 32'(outs()), 32'b101_1_1101_0);
        probe("R2 lower window beyond upper", 32'h0000_1800, 1, 1, 1, 1, 0);
        check("R2 lower write ok", 32'(fault), 32'd0);

        // R4: mask slice 1 (0x1080..0x10FF)
        cfg_write(5, 1, {16'd0, 8'b0000_0010, 2'd0, 5'd9, 1'b1});
        probe("R4 masked slice falls through", 32'h0000_1080, 1, 1, 1, 1, 0);
        check("R4 masked write ok", 32'(outs()), 32'b111_0_0000_0);
        probe("R4 slice edge unmasked", 32'h0000_107F, 1, 1, 1, 1, 0);
        check("R4 unmasked refused", 32'(fault_status), 32'hD);
        probe("R4 next slice unmasked", 32'h0000_1100, 1, 1, 1, 1, 0);

        // R5: 128-byte window with all mask bits set
        region(7, 32'h0000_3000, {16'd0, 8'hFF, 2'd0, 5'd6, 1'b1}, 32'h0000_0300);
        probe("R5 small window ignores mask", 32'h0000_3010, 1, 1, 1, 1, 0);
        check("R5 write ok", 32'(outs()), 32'b111_0_0000_0);

        // R6 / R7 / R8: every permission code
        for (int ap = 0; ap < 8; ap++) begin
            for (int xn = 0; xn < 2; xn++) begin
                cfg_write(7, 2, (32'(xn) << 12) | (32'(ap) << 8));
                for (int k = 0; k < 3; k++) begin
                    probe("R6 unprivileged code", 32'h0000_3040, 2'(k), 1, 1, 1, 0);
                    probe("R7 privileged code", 32'h0000_3040, 2'(k), 0, 1, 1, 0);
                end
            end
        end
        cfg_write(7, 2, 32'h0000_1300);
        probe("R8 no-exec on full access", 32'h0000_3000, 2, 0, 1, 1, 0);
        check("R8 exec refused", 32'(outs()), 32'b110_1_1101_0);
        cfg_write(7, 2, 32'h0000_0400);
        probe("R7 reserved code 4 priv", 32'h0000_3000, 0, 0, 1, 1, 0);
        check("R7 code 4 denies", 32'(outs()), 32'b000_1_1101_0);

        // R10 default map
        probe("R10 off low exec", 32'h7FFF_FFFC, 2, 1, 0, 0, 0);
        check("R10 low exec ok", 32'(outs()), 32'b111_0_0000_0);
        probe("R10 off mid exec", 32'h8000_0000, 2, 1, 0, 0, 1);
        check("R10 mid exec refused", 32'(outs()), 32'b110_1_1101_0);
        probe("R10 off high exec no hv", 32'hF000_0000, 2, 0, 0, 0, 0);
        check("R10 high exec refused", 32'(fault), 32'd1);
        probe("R10 off high exec hv", 32'hF000_0000, 2, 0, 0, 0, 1);
        check("R10 high exec with hv", 32'(fault), 32'd0);
        probe("R10 priv miss background", 32'h9000_0000, 1, 0, 1, 1, 0);
        check("R10 background write ok", 32'(outs()), 32'b110_0_0000_0);

        // R11 kind 3
        probe("R11 kind 3 refused", 32'h0000_1800, 3, 0, 1, 1, 0);
        check("R11 kind 3 code", 32'(outs()), 32'b111_1_1101_0);

        // R12 hold and ignored select
        @(negedge clk);
        req_addr = 32'h9000_0000; req_kind = 0; req_user = 1;
        @(negedge clk);
        check("R12 rsp_valid low when idle", 32'(rsp_valid), 32'd0);
        check("R12 result held", 32'(outs()), 32'b111_1_1101_0);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 0; cfg_sel = 3; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_we = 0;
        probe("R12 select 3 leaves window", 32'h0000_1800, 1, 1, 1, 1, 0);
        check("R12 window 0 still writable", 32'(outs()), 32'b111_0_0000_0);

        // random sweep (R2 R3 R4 R6 R7 R8 R9 R10 R11)
        for (int i = 0; i < 16; i++) begin
            int k;
            logic [31:0] mask;
            k = 4 + int'($urandom % 20);
            mask = ~((32'd1 << (k + 1)) - 1);
            region(i, ($urandom % 32'h0100_0000) & mask,
                   {16'd0, 8'($urandom), 2'd0, 5'(k), 1'($urandom % 8 != 0)},
                   ($urandom & 32'h0000_1700));
        end
        for (int t = 0; t < 3000; t++) begin
            int r;
            logic [31:0] a;
            r = int'($urandom % 16);
            if ($urandom % 8 == 0) a = $urandom;
            else a = m_base[r] + ($urandom & ((32'd1 << (m_size[r][5:1] + 1)) - 1));
            probe("RND R2 R4 R6 R7 R9", a, 2'($urandom % 4), 1'($urandom),
                  1'($urandom % 8 != 0), 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

endmodule